// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialisation Sequencer

This block brings a DDR SDRAM device out of power-up before the main memory controller takes over the command bus. Once its start input is seen, it raises the clock-enable line and plays out a fixed series of eight commands. Between commands it inserts a programmable number of idle cycles. After the last command it waits a longer, separately programmed interval and then raises a done flag. The done flag hands the bus to the main controller.

The series selects a specific bring-up order. It first disables the device's DLL through the extended mode register. It then loads the base mode register with the DLL-reset bit set. Two auto-refresh commands follow. A final base mode load carries the same settings with DLL reset cleared. The mode-register words are assembled from the CAS latency and burst-length codes given as parameters. The row address width is also a parameter. On every clock that is not a command slot the bus carries NOP with zero address.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: While reset is asserted, and afterwards until a start is seen, CKE is low, the command lines read NOP (RAS#,CAS#,WE# = 1,1,1), row and bank are zero and done is low.
- R2: A start sampled high at a clock edge in the idle state makes the following cycle the first command slot. From that slot on, CKE is high and stays high until reset.
- R3: Command slot k (k = 0..7) carries, in order: NOP, PRECHARGE ALL, LOAD MODE, LOAD MODE, PRECHARGE ALL, AUTO REFRESH, AUTO REFRESH, LOAD MODE. The RAS#,CAS#,WE# encodings are NOP=111, PRECHARGE=010, AUTO REFRESH=001 and LOAD MODE=000.
- R4: Both PRECHARGE ALL slots drive row 0x400 (A10 high) with bank 00.
- R5: The first LOAD MODE (slot 2) drives bank 01 with row 0x001, which disables the DLL.
- R6: The second LOAD MODE (slot 3) drives bank 00 with row 0x121. In that word, bit 8 is DLL reset, bits 6:4 are CAS latency 2 and bits 2:0 are burst code 1 (length 2).
- R7: The last LOAD MODE (slot 7) drives bank 00 with row 0x021, the slot-3 word with bit 8 cleared.
- R8: Exactly GAP_CYC NOP cycles separate consecutive command slots, so slot k falls k*(GAP_CYC+1) cycles after slot 0.
- R9: Done rises exactly FINAL_CYC+1 cycles after slot 7; the bus carries NOP in the cycles between.
- R10: Once high, done stays high until reset, the bus stays at NOP with CKE high, and start has no effect.
- R11: Start pulses while the sequence is running do not restart or disturb it.
- R12: Row and bank are zero on every cycle that is not a command slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin the power-up series (idle state only) |
| cke_o | output | 1 | Clock enable to the device |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| row_addr_o | output | ROW_W | Row address lines |
| bank_o | output | 2 | Bank address |
| done_o | output | 1 | Series finished, bus handed over |

## Verification
The bench builds the block with a 12-bit row, a gap of 3 cycles and a final wait of 9 cycles. The narrow row shows that the 0x400 precharge word still fits once the width drops below its default. The short waits place all eight slots, the tail and the done edge within about forty cycles, so every cycle can be compared against a slot-position formula. Start pulses are injected in the gaps, in the tail and after done. Reset is applied in mid-series to show a clean restart.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  localparam int STEPS     = 8;
  localparam int BANK_W    = 2;
  localparam int CORE_ROWS = 11;

  typedef enum logic [2:0] {
    CMD_LMR = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_NOP = 3'b111
  } ddr_cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_GAP,
    ST_TAIL,
    ST_DONE
  } seq_state_e;

  // base mode word: [8] dll reset, [6:4] cas latency, [2:0] burst code
  function automatic logic [CORE_ROWS-1:0] base_mode(input logic dll_rst,
                                                     input logic [2:0] cas_lat,
                                                     input logic [2:0] burst_code);
    return {2'b00, dll_rst, 1'b0, cas_lat, 1'b0, burst_code};
  endfunction

  // extended mode word: [0] dll disable
  function automatic logic [CORE_ROWS-1:0] ext_mode(input logic dll_off);
    return {{(CORE_ROWS-1){1'b0}}, dll_off};
  endfunction

  function automatic logic [CORE_ROWS-1:0] pre_all_row();
    return 11'h400;
  endfunction

  function automatic ddr_cmd_e step_cmd(input int idx);
    case (idx)
      0:       return CMD_NOP;
      1, 4:    return CMD_PRE;
      5, 6:    return CMD_REF;
      default: return CMD_LMR;
    endcase
  endfunction

  function automatic logic [BANK_W-1:0] step_bank(input int idx);
    return (idx == 2) ? 2'b01 : 2'b00;
  endfunction

  function automatic logic [CORE_ROWS-1:0] step_row(input int idx,
                                                    input logic [2:0] cas_lat,
                                                    input logic [2:0] burst_code);
    case (idx)
      1, 4:    return pre_all_row();
      2:       return ext_mode(1'b1);
      3:       return base_mode(1'b1, cas_lat, burst_code);
      7:       return base_mode(1'b0, cas_lat, burst_code);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/ddr_init_steps.sv
module ddr_init_steps
  import ddr_init_pkg::*;
#(
  parameter int         ROW_W      = 13,
  parameter logic [2:0] CAS_LAT    = 3'd2,
  parameter logic [2:0] BURST_CODE = 3'd1,
  localparam int        IDX_W      = $clog2(STEPS)
) (
  input  logic [IDX_W-1:0]  idx_i,
  output ddr_cmd_e          cmd_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ROW_W-1:0]  row_o
);

  ddr_cmd_e          cmd_tbl  [STEPS];
  logic [BANK_W-1:0] bank_tbl [STEPS];
  logic [ROW_W-1:0]  row_tbl  [STEPS];

  for (genvar i = 0; i < STEPS; i++) begin : g_step
    assign cmd_tbl[i]  = step_cmd(i);
    assign bank_tbl[i] = step_bank(i);
    assign row_tbl[i]  = ROW_W'(step_row(i, CAS_LAT, BURST_CODE));
  end

  assign cmd_o  = cmd_tbl[idx_i];
  assign bank_o = bank_tbl[idx_i];
  assign row_o  = row_tbl[idx_i];

endmodule

// File: rtl/ddr_init_ctrl.sv
module ddr_init_ctrl
  import ddr_init_pkg::*;
#(
  parameter int  GAP_CYC   = 4,
  parameter int  FINAL_CYC = 100,
  localparam int IDX_W     = $clog2(STEPS),
  localparam int MAX_WAIT  = (GAP_CYC > FINAL_CYC) ? GAP_CYC : FINAL_CYC,
  localparam int CNT_W     = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             powered_o,
  output logic             slot_fire_o,
  output logic             last_slot_o,
  output logic             tail_busy_o,
  output logic             done_o
);

  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(STEPS - 1);
  localparam logic [CNT_W-1:0] GAP_LD    = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] FINAL_LD  = CNT_W'(FINAL_CYC - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic             tmr_zero;
  logic             at_last;

  assign at_last = (idx_q == LAST_IDX);

  ddr_init_timer #(.CNT_W(CNT_W)) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (state_q == ST_CMD),
    .load_val_i (at_last ? FINAL_LD : GAP_LD),
    .run_i      ((state_q == ST_GAP) || (state_q == ST_TAIL)),
    .zero_o     (tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_CMD;
          idx_q   <= '0;
        end
        ST_CMD:  state_q <= at_last ? ST_TAIL : ST_GAP;
        ST_GAP:  if (tmr_zero) begin
          state_q <= ST_CMD;
          idx_q   <= idx_q + 1'b1;
        end
        ST_TAIL: if (tmr_zero) state_q <= ST_DONE;
        ST_DONE: state_q <= ST_DONE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idx_o       = idx_q;
  assign powered_o   = (state_q != ST_IDLE);
  assign slot_fire_o = (state_q == ST_CMD);
  assign last_slot_o = (state_q == ST_CMD) && at_last;
  assign tail_busy_o = (state_q == ST_TAIL);
  assign done_o      = (state_q == ST_DONE);

endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
  import ddr_init_pkg::*;
#(
  parameter int         ROW_W      = 13,
  parameter int         GAP_CYC    = 4,
  parameter int         FINAL_CYC  = 100,
  parameter logic [2:0] CAS_LAT    = 3'd2,
  parameter logic [2:0] BURST_CODE = 3'd1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  output logic             cke_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic [ROW_W-1:0] row_addr_o,
  output logic [1:0]       bank_o,
  output logic             done_o
);

  localparam int IDX_W = $clog2(STEPS);

  logic [IDX_W-1:0]  step_idx;
  logic              powered;
  logic              slot_fire;
  logic              last_slot;
  logic              tail_busy;
  ddr_cmd_e          tbl_cmd;
  logic [BANK_W-1:0] tbl_bank;
  logic [ROW_W-1:0]  tbl_row;
  ddr_cmd_e          bus_cmd;

  ddr_init_ctrl #(
    .GAP_CYC   (GAP_CYC),
    .FINAL_CYC (FINAL_CYC)
  ) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .idx_o       (step_idx),
    .powered_o   (powered),
    .slot_fire_o (slot_fire),
    .last_slot_o (last_slot),
    .tail_busy_o (tail_busy),
    .done_o      (done_o)
  );

  ddr_init_steps #(
    .ROW_W      (ROW_W),
    .CAS_LAT    (CAS_LAT),
    .BURST_CODE (BURST_CODE)
  ) steps_i (
    .idx_i  (step_idx),
    .cmd_o  (tbl_cmd),
    .bank_o (tbl_bank),
    .row_o  (tbl_row)
  );

  assign bus_cmd    = slot_fire ? tbl_cmd : CMD_NOP;
  assign ras_n_o    = bus_cmd[2];
  assign cas_n_o    = bus_cmd[1];
  assign we_n_o     = bus_cmd[0];
  assign row_addr_o = slot_fire ? tbl_row : '0;
  assign bank_o     = slot_fire ? tbl_bank : '0;
  assign cke_o      = powered;

endmodule

// File: rtl/ddr_init_chk.sv
module ddr_init_chk #(
  parameter int ROW_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke_o,
  input logic             ras_n_o,
  input logic             cas_n_o,
  input logic             we_n_o,
  input logic [ROW_W-1:0] row_addr_o,
  input logic [1:0]       bank_o,
  input logic             done_o,
  input logic             slot_fire,
  input logic             last_slot,
  input logic             tail_busy
);

  logic [2:0] cmd;
  assign cmd = {ras_n_o, cas_n_o, we_n_o};

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cke_o |-> (cmd == 3'b111) && (row_addr_o == '0) && (bank_o == '0) && !done_o);

  a_r2_cke_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cke_o |=> cke_o);

  a_r3_legal_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    slot_fire |-> (cmd == 3'b111) || (cmd == 3'b010) || (cmd == 3'b001) || (cmd == 3'b000));

  a_r4_pre_a10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b010) |-> (row_addr_o == ROW_W'(11'h400)) && (bank_o == 2'b00));

  a_r5_ext_dll_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == 3'b000) && (bank_o == 2'b01) |-> (row_addr_o == ROW_W'(1)));

  a_r8_gap_nop: assert property (@(posedge clk) disable iff (!rst_n)
    slot_fire && !last_slot |=> (cmd == 3'b111) && !slot_fire);

  a_r9_done_after_tail: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(tail_busy));

  a_r10_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> done_o);

  a_r10_done_bus_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cmd == 3'b111) && cke_o && !slot_fire);

  a_r12_nop_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_fire |-> (cmd == 3'b111) && (row_addr_o == '0) && (bank_o == '0));

endmodule

bind ddr_pwrup_seq ddr_init_chk #(.ROW_W(ROW_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cke_o      (cke_o),
  .ras_n_o    (ras_n_o),
  .cas_n_o    (cas_n_o),
  .we_n_o     (we_n_o),
  .row_addr_o (row_addr_o),
  .bank_o     (bank_o),
  .done_o     (done_o),
  .slot_fire  (slot_fire),
  .last_slot  (last_slot),
  .tail_busy  (tail_busy)
);

// File: tb/ddr_pwrup_seq_tb_top.sv
module ddr_pwrup_seq_tb_top;

  localparam int ROW_W   = 12;
  localparam int GAP     = 3;
  localparam int FIN     = 9;
  localparam int SLOT    = GAP + 1;
  localparam int DONE_AT = 7 * SLOT + 1 + FIN;

  // {ras_n,cas_n,we_n, bank[1:0], row[15:0]} per slot
  localparam logic [20:0] EXP_TBL [8] = '{
    {3'b111, 2'd0, 16'h0000},
    {3'b010, 2'd0, 16'h0400},
    {3'b000, 2'd1, 16'h0001},
    {3'b000, 2'd0, 16'h0121},
    {3'b010, 2'd0, 16'h0400},
    {3'b001, 2'd0, 16'h0000},
    {3'b001, 2'd0, 16'h0000},
    {3'b000, 2'd0, 16'h0021}
  };
  localparam logic [20:0] NOP_BUS = {3'b111, 2'd0, 16'h0000};

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             cke, ras_n, cas_n, we_n, done;
  logic [ROW_W-1:0] row;
  logic [1:0]       bank;
  int               total = 0;
  int               bad = 0;
  bit               finished = 1'b0;

  always #5 clk = ~clk;

  ddr_pwrup_seq #(
    .ROW_W     (ROW_W),
    .GAP_CYC   (GAP),
    .FINAL_CYC (FIN)
  ) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .cke_o      (cke),
    .ras_n_o    (ras_n),
    .cas_n_o    (cas_n),
    .we_n_o     (we_n),
    .row_addr_o (row),
    .bank_o     (bank),
    .done_o     (done)
  );

  function automatic logic [20:0] bus_now();
    return {ras_n, cas_n, we_n, bank, 16'(row)};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic check_bus(input string req, input logic [20:0] exp);
    check(bus_now() == exp, req, 32'(bus_now()), 32'(exp));
  endtask

  task automatic check_quiet(input string req);
    check(cke == 1'b0, req, 32'(cke), 32'd0);
    check_bus(req, NOP_BUS);
    check(done == 1'b0, req, 32'(done), 32'd0);
  endtask

  initial begin
    bit pulsed = 1'b0;
    repeat (3) @(negedge clk);
    check_quiet("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_quiet("R1 idle before start");

    // main walk over the expected slot table
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= DONE_AT + 5; c++) begin
      string tag;
      logic [20:0] e;
      int k;
      bit slot;
      k = c / SLOT;
      slot = ((c % SLOT) == 0) && (k < 8);
      e = slot ? EXP_TBL[k] : NOP_BUS;
      if (slot) begin
        case (k)
          0: tag = "R2 first slot";
          1, 4: tag = "R4 precharge all";
          2: tag = "R5 ext mode dll off";
          3: tag = "R6 mode dll reset";
          7: tag = "R7 mode dll clear";
          default: tag = "R3 refresh order";
        endcase
      end else if (k < 7) begin
        tag = "R8 gap nop R12";
      end else if (c < DONE_AT) begin
        tag = "R9 tail nop";
      end else begin
        tag = "R10 after done";
      end
      if (pulsed) tag = {tag, " R11 start while busy"};
      check(cke == 1'b1, tag, 32'(cke), 32'd1);
      check_bus(tag, e);
      check(done == (c >= DONE_AT), {tag, " done"}, 32'(done), 32'(c >= DONE_AT));
      pulsed = (c == 5) || (c == 17) || (c == 30) || (c == 33);
      start = pulsed;
      @(negedge clk);
    end
    start = 1'b0;

    // R10: start pulses after done do nothing
    for (int i = 0; i < 8; i++) begin
      start = ~start;
      @(negedge clk);
      check(done == 1'b1, "R10 done sticky", 32'(done), 32'd1);
      check(cke == 1'b1, "R10 cke high", 32'(cke), 32'd1);
      check_bus("R10 bus idle", NOP_BUS);
    end
    start = 1'b0;

    // reset in mid-series, then restart
    rst_n = 1'b0;
    @(negedge clk);
    check_quiet("R1 reset after done");
    rst_n = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cke == 1'b1, "R2 restart cke", 32'(cke), 32'd1);
    check_bus("R2 restart slot0", EXP_TBL[0]);
    repeat (SLOT) @(negedge clk);
    check_bus("R4 restart precharge", EXP_TBL[1]);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check_quiet("R1 reset mid series");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_quiet("R1 idle without start");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule